// File: doc/BRIEF.md
# Transmit Mailbox Priority Arbiter

This block decides which of a bank of message mailboxes a CAN controller transmits next. Every mailbox has an enable bit, a direction bit, a pending-request bit and a stored control word, and the control word holds a priority, a remote-request flag and a payload length. Software raises requests with a write-one-to-set strobe, cancels them with a write-one abort strobe or by clearing the enable bit, and clears completion flags with a write-one-to-clear strobe.

When the transmitter is idle, the arbiter considers every enabled transmit mailbox that has a request. It picks the one with the largest priority value, and a tie goes to the higher mailbox index. It then starts a send handshake toward the bit engine and holds the mailbox index and the control fields steady until the engine reports completion. A frame that has already started is never pre-empted. A successful completion sets the mailbox's acknowledge flag and drops its request. A failed attempt leaves the request in place, so the mailbox competes again. A global interrupt output is raised while any acknowledge flag is set whose mask bit is enabled.

Top module: `txmb_arbiter`

## Requirements
- R1: After reset, and while reset is held, `send_valid`, `tx_req`, `tx_ack` and `irq` are all zero, and every enable, direction and mask bit is zero.
- R2: A `req_set_we` strobe sets `tx_req` bit i for each 1 bit in `req_set_data` whose mailbox is enabled. Zero bits leave the request unchanged, and a request to a disabled mailbox is not kept.
- R3: A mailbox can be granted only when its request is pending, its enable bit is 1 and its direction bit is 0. A direction value of 1 marks a receive mailbox, which keeps its request but is never granted.
- R4: Among eligible mailboxes, the grant goes to the mailbox with the numerically largest 6-bit priority value.
- R5: When eligible mailboxes share the largest priority value, the grant goes to the highest mailbox index among them.
- R6: A control write stores priority from `ctl_word[13:8]`, the remote flag from bit 4 and the length from bits 3:0. `send_valid` rises on the clock after an eligible request is present while idle, and it carries `send_idx` with the stored fields.
- R7: While `send_valid` is high and `send_done` is low, `send_idx`, `send_prio`, `send_rtr` and `send_len` do not change, even when a higher-priority request arrives.
- R8: When `send_done` is asserted with `send_ok`=1 during a send, `send_valid` drops on the next clock. If the request is still pending, its acknowledge bit is set and its request is cleared. `send_done` has no effect while idle.
- R9: When `send_done` is asserted with `send_ok`=0, `send_valid` drops, no acknowledge bit is set, and the request stays pending so the mailbox is granted again.
- R10: An `ack_clr_we` strobe clears each `tx_ack` bit written as 1 and leaves the bits written as 0 untouched.
- R11: `irq` is 1 exactly when some `tx_ack` bit is set and its mask bit, written through `mask_we`/`mask_data`, is 1.
- R12: Clearing a mailbox's enable bit cancels its request without setting its acknowledge bit. If that mailbox is already being sent, the send still runs to `send_done`, and its completion then sets no acknowledge bit.
- R13: An `abort_we` strobe clears the request of each mailbox written as 1 and sets no acknowledge bit. It has the same in-flight behaviour as R12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_idx | input | IDX_W | Mailbox addressed by the control write |
| ctl_word | input | 16 | Control word: priority 13:8, remote flag 4, length 3:0 |
| en_we | input | 1 | Enable register write strobe |
| en_data | input | N_MB | New enable bits |
| dir_we | input | 1 | Direction register write strobe |
| dir_data | input | N_MB | New direction bits (1 = receive) |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_data | input | N_MB | New interrupt mask bits |
| req_set_we | input | 1 | Request set strobe |
| req_set_data | input | N_MB | Write-one-to-set request bits |
| abort_we | input | 1 | Abort strobe |
| abort_data | input | N_MB | Write-one cancel request bits |
| ack_clr_we | input | 1 | Acknowledge clear strobe |
| ack_clr_data | input | N_MB | Write-one-to-clear acknowledge bits |
| send_valid | output | 1 | A frame is being handed to the bit engine |
| send_idx | output | IDX_W | Mailbox being sent |
| send_prio | output | 6 | Priority of the mailbox being sent |
| send_rtr | output | 1 | Remote-request flag of the mailbox being sent |
| send_len | output | 4 | Length field of the mailbox being sent |
| send_done | input | 1 | Bit engine finished the attempt |
| send_ok | input | 1 | The finished attempt succeeded |
| tx_req | output | N_MB | Pending requests |
| tx_ack | output | N_MB | Acknowledge flags |
| irq | output | 1 | Global mailbox interrupt |

## Verification
The bench builds the block with its default of 32 mailboxes, so mailbox 31, mailbox 0 and the full priority range from 0 to 63 all take part. Every mailbox gets its own priority through the control port, and many requests are raised in one write. Each vector then drains a full queue, so the bench observes the whole grant order, including ties where all 32 mailboxes share priority 0 or 63. Directed cases cover failed sends, cancellation of a mailbox that is pending or already in flight, and the interrupt mask.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
    localparam int PRIO_W   = 6;
    localparam int LEN_W    = 4;
    localparam int CTL_W    = 16;
    localparam int PRIO_LSB = 8;
    localparam int RTR_POS  = 4;
    localparam int LEN_LSB  = 0;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef struct packed {
        prio_t prio;
        logic  rtr;
        len_t  len;
    } mb_ctl_t;

    function automatic mb_ctl_t unpack_ctl(input logic [CTL_W-1:0] w);
        mb_ctl_t c;
        c.prio = w[PRIO_LSB +: PRIO_W];
        c.rtr  = w[RTR_POS];
        c.len  = w[LEN_LSB +: LEN_W];
        return c;
    endfunction
endpackage

// File: rtl/txarb_ctl_store.sv
module txarb_ctl_store
    import txarb_pkg::*;
#(
    parameter int N_MB  = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [CTL_W-1:0] word,
    output mb_ctl_t          ctl_o [N_MB]
);
    mb_ctl_t ctl_d [N_MB];
    mb_ctl_t ctl_q [N_MB];

    always_comb begin
        for (int i = 0; i < N_MB; i++) begin
            ctl_d[i] = ctl_q[i];
        end
        if (we && (int'(idx) < N_MB)) begin
            ctl_d[idx] = unpack_ctl(word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_MB; i++) begin
                ctl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_MB; i++) begin
                ctl_q[i] <= ctl_d[i];
            end
        end
    end

    assign ctl_o = ctl_q;
endmodule

// File: rtl/txarb_pick.sv
module txarb_pick
    import txarb_pkg::*;
#(
    parameter int N_MB  = 32,
    parameter int IDX_W = 5
) (
    input  logic [N_MB-1:0]  elig,
    input  mb_ctl_t          ctl_i [N_MB],
    output logic             found,
    output logic [IDX_W-1:0] win_idx,
    output mb_ctl_t          win_ctl
);
    // Ascending scan: ">=" lets a later (higher) index take over on a tie.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_ctl = '0;
        for (int i = 0; i < N_MB; i++) begin
            if (elig[i] && (!found || (ctl_i[i].prio >= win_ctl.prio))) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_ctl = ctl_i[i];
            end
        end
    end
endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter
    import txarb_pkg::*;
#(
    parameter  int N_MB  = 32,
    localparam int IDX_W = (N_MB > 1) ? $clog2(N_MB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [IDX_W-1:0]  ctl_idx,
    input  logic [CTL_W-1:0]  ctl_word,
    input  logic              en_we,
    input  logic [N_MB-1:0]   en_data,
    input  logic              dir_we,
    input  logic [N_MB-1:0]   dir_data,
    input  logic              mask_we,
    input  logic [N_MB-1:0]   mask_data,
    input  logic              req_set_we,
    input  logic [N_MB-1:0]   req_set_data,
    input  logic              abort_we,
    input  logic [N_MB-1:0]   abort_data,
    input  logic              ack_clr_we,
    input  logic [N_MB-1:0]   ack_clr_data,
    output logic              send_valid,
    output logic [IDX_W-1:0]  send_idx,
    output logic [PRIO_W-1:0] send_prio,
    output logic              send_rtr,
    output logic [LEN_W-1:0]  send_len,
    input  logic              send_done,
    input  logic              send_ok,
    output logic [N_MB-1:0]   tx_req,
    output logic [N_MB-1:0]   tx_ack,
    output logic              irq
);
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] cur;
        mb_ctl_t          cur_ctl;
        logic [N_MB-1:0]  req;
        logic [N_MB-1:0]  ack;
        logic [N_MB-1:0]  en;
        logic [N_MB-1:0]  dir;
        logic [N_MB-1:0]  mask;
    } arb_st_t;

    arb_st_t s_d, s_q;

    mb_ctl_t          ctl_arr [N_MB];
    logic [N_MB-1:0]  elig;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    mb_ctl_t          pick_ctl;

    txarb_ctl_store #(.N_MB(N_MB), .IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .idx   (ctl_idx),
        .word  (ctl_word),
        .ctl_o (ctl_arr)
    );

    assign elig = s_q.req & s_q.en & ~s_q.dir;

    txarb_pick #(.N_MB(N_MB), .IDX_W(IDX_W)) u_pick (
        .elig    (elig),
        .ctl_i   (ctl_arr),
        .found   (pick_found),
        .win_idx (pick_idx),
        .win_ctl (pick_ctl)
    );

    logic [N_MB-1:0] cur_bit;
    logic            done_ok;
    logic            cur_pending;

    always_comb begin
        cur_bit     = {{(N_MB-1){1'b0}}, 1'b1} << s_q.cur;
        done_ok     = s_q.busy && send_done && send_ok;
        cur_pending = |(s_q.req & cur_bit);

        s_d = s_q;

        if (en_we)   s_d.en   = en_data;
        if (dir_we)  s_d.dir  = dir_data;
        if (mask_we) s_d.mask = mask_data;

        // requests: completion clears, set wins over it, abort and disable cancel
        s_d.req = s_q.req;
        if (done_ok)    s_d.req = s_d.req & ~cur_bit;
        if (req_set_we) s_d.req = s_d.req | req_set_data;
        if (abort_we)   s_d.req = s_d.req & ~abort_data;
        s_d.req = s_d.req & s_d.en;

        // acknowledge: W1C, a new completion wins over a same-cycle clear
        s_d.ack = s_q.ack;
        if (ack_clr_we)             s_d.ack = s_d.ack & ~ack_clr_data;
        if (done_ok && cur_pending) s_d.ack = s_d.ack | cur_bit;

        if (s_q.busy) begin
            if (send_done) begin
                s_d.busy = 1'b0;
            end
        end else if (pick_found) begin
            s_d.busy    = 1'b1;
            s_d.cur     = pick_idx;
            s_d.cur_ctl = pick_ctl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign send_valid = s_q.busy;
    assign send_idx   = s_q.cur;
    assign send_prio  = s_q.cur_ctl.prio;
    assign send_rtr   = s_q.cur_ctl.rtr;
    assign send_len   = s_q.cur_ctl.len;
    assign tx_req     = s_q.req;
    assign tx_ack     = s_q.ack;
    assign irq        = |(s_q.ack & s_q.mask);
endmodule

// File: rtl/txmb_arbiter_chk.sv
module txmb_arbiter_chk #(
    parameter int N_MB  = 32,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_we,
    input logic             req_set_we,
    input logic             abort_we,
    input logic             send_valid,
    input logic [IDX_W-1:0] send_idx,
    input logic [5:0]       send_prio,
    input logic             send_rtr,
    input logic [3:0]       send_len,
    input logic             send_done,
    input logic             send_ok,
    input logic [N_MB-1:0]  tx_req,
    input logic [N_MB-1:0]  tx_ack,
    input logic             irq
);
    a_r7_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid && !send_done |=> send_valid && $stable(send_idx) &&
        $stable(send_prio) && $stable(send_rtr) && $stable(send_len));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid && send_done |=> !send_valid);

    a_r8_ack_set: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid && send_done && send_ok && tx_req[send_idx]
        |=> tx_ack[$past(send_idx)]);

    a_r9_keep_req: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid && send_done && !send_ok && tx_req[send_idx] &&
        !abort_we && !en_we |=> tx_req[$past(send_idx)]);

    a_r2_req_source: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tx_req & ~$past(tx_req))) |-> $past(req_set_we));

    a_r10_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tx_ack & ~$past(tx_ack))) |-> $past(send_valid && send_done && send_ok));

    a_r11_irq_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|tx_ack));

    a_r3_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(send_valid) |->
        (($past(tx_req) & ({{(N_MB-1){1'b0}}, 1'b1} << send_idx)) != '0));
endmodule

bind txmb_arbiter txmb_arbiter_chk #(.N_MB(N_MB), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_we      (en_we),
    .req_set_we (req_set_we),
    .abort_we   (abort_we),
    .send_valid (send_valid),
    .send_idx   (send_idx),
    .send_prio  (send_prio),
    .send_rtr   (send_rtr),
    .send_len   (send_len),
    .send_done  (send_done),
    .send_ok    (send_ok),
    .tx_req     (tx_req),
    .tx_ack     (tx_ack),
    .irq        (irq)
);

// File: tb/tb_txmb_arbiter.sv
module tb_txmb_arbiter;
    localparam int N  = 32;
    localparam int IW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          ctl_we = 0;       logic [IW-1:0] ctl_idx = '0;  logic [15:0] ctl_word = '0;
    logic          en_we = 0;        logic [N-1:0]  en_data = '0;
    logic          dir_we = 0;       logic [N-1:0]  dir_data = '0;
    logic          mask_we = 0;      logic [N-1:0]  mask_data = '0;
    logic          req_set_we = 0;   logic [N-1:0]  req_set_data = '0;
    logic          abort_we = 0;     logic [N-1:0]  abort_data = '0;
    logic          ack_clr_we = 0;   logic [N-1:0]  ack_clr_data = '0;
    logic          send_done = 0;    logic          send_ok = 0;
    logic          send_valid, send_rtr, irq;
    logic [IW-1:0] send_idx;
    logic [5:0]    send_prio;
    logic [3:0]    send_len;
    logic [N-1:0]  tx_req, tx_ack;

    txmb_arbiter #(.N_MB(N)) dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    int m_prio [N];
    int m_len  [N];
    int m_rtr  [N];

    // {request mask, priority seed}; seed bit 7 = every mailbox gets seed[5:0]
    localparam logic [39:0] VEC [10] = '{
        {32'h8000_0001, 8'h05},
        {32'hFFFF_FFFF, 8'h80},
        {32'hF0F0_0F0F, 8'hBF},
        {32'h0000_00FF, 8'h13},
        {32'hAAAA_5555, 8'h2D},
        {32'h1234_5678, 8'h7F},
        {32'h8421_8421, 8'h9A},
        {32'hFFFF_0000, 8'h41},
        {32'h0000_0003, 8'h00},
        {32'h7E00_0081, 8'h66}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int prio_of(input int i, input logic [7:0] seed);
        if (seed[7]) return int'(seed[5:0]);
        return ((i * int'(seed[6:0]) + int'(seed)) ^ (i << 1)) & 63;
    endfunction

    function automatic int ref_pick(input logic [N-1:0] pend);
        int best = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i] && (best < 0 || m_prio[i] > m_prio[best])) best = i;
        end
        return best;
    endfunction

    task automatic w_ctl(input int idx, input int p, input int r, input int l);
        ctl_we = 1; ctl_idx = IW'(idx);
        ctl_word = {2'b00, 6'(p), 3'b000, 1'(r), 4'(l)};
        m_prio[idx] = p; m_rtr[idx] = r; m_len[idx] = l;
        step(); ctl_we = 0;
    endtask
    task automatic w_en(input logic [N-1:0] d);   en_we = 1;  en_data = d;  step(); en_we = 0;  endtask
    task automatic w_dir(input logic [N-1:0] d);  dir_we = 1; dir_data = d; step(); dir_we = 0; endtask
    task automatic w_mask(input logic [N-1:0] d); mask_we = 1; mask_data = d; step(); mask_we = 0; endtask
    task automatic w_req(input logic [N-1:0] d);  req_set_we = 1; req_set_data = d; step(); req_set_we = 0; endtask
    task automatic w_abort(input logic [N-1:0] d); abort_we = 1; abort_data = d; step(); abort_we = 0; endtask
    task automatic w_ackclr(input logic [N-1:0] d); ack_clr_we = 1; ack_clr_data = d; step(); ack_clr_we = 0; endtask
    task automatic done(input bit ok);
        send_done = 1; send_ok = ok; step(); send_done = 0; send_ok = 0;
    endtask
    task automatic wait_grant();
        for (int t = 0; t < 8 && !send_valid; t++) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check(send_valid == 0, "R1 send_valid", send_valid, 0);
        check(tx_req == 0, "R1 tx_req", tx_req, 0);
        check(tx_ack == 0 && irq == 0, "R1 ack/irq", {tx_ack, irq}, 0);

        w_en('1);
        w_dir('0);

        // table of vectors: full drain checks R4 R5 R6 R8
        for (int v = 0; v < 10; v++) begin
            logic [N-1:0] pend;
            logic [7:0]   seed;
            pend = VEC[v][39:8];
            seed = VEC[v][7:0];
            for (int i = 0; i < N; i++) w_ctl(i, prio_of(i, seed), i & 1, (i + int'(seed)) & 15);
            w_req(pend);
            while (pend != 0) begin
                int exp_i;
                exp_i = ref_pick(pend);
                wait_grant();
                check(send_valid == 1, "R6 grant", send_valid, 1);
                check(int'(send_idx) == exp_i, "R4 R5 winner", send_idx, exp_i);
                check(int'(send_prio) == m_prio[exp_i] && int'(send_rtr) == m_rtr[exp_i] &&
                      int'(send_len) == m_len[exp_i], "R6 fields",
                      {send_prio, send_rtr, send_len},
                      {6'(m_prio[exp_i]), 1'(m_rtr[exp_i]), 4'(m_len[exp_i])});
                done(1);
                check(tx_ack[exp_i] == 1 && tx_req[exp_i] == 0, "R8 ack on success",
                      {tx_ack[exp_i], tx_req[exp_i]}, 2'b10);
                pend[exp_i] = 1'b0;
            end
            w_ackclr('1);
        end

        for (int i = 0; i < N; i++) w_ctl(i, 0, 0, 0);

        // R2 zero write and disabled target
        w_req('0);
        check(tx_req == 0, "R2 zero bits", tx_req, 0);
        w_en(~(N'(1) << 5));
        w_req(N'(1) << 5);
        check(tx_req == 0, "R2 disabled dropped", tx_req, 0);
        w_en('1);

        // R3 receive mailbox keeps request, never granted
        w_ctl(9, 63, 0, 0);
        w_dir(N'(1) << 9);
        w_req(N'(1) << 9);
        step(); step();
        check(tx_req == (N'(1) << 9) && send_valid == 0, "R3 receive not granted",
              {tx_req, send_valid}, {N'(1) << 9, 1'b0});
        w_ctl(2, 1, 0, 0);
        w_req(N'(1) << 2);
        wait_grant();
        check(send_idx == 2, "R3 transmit granted", send_idx, 2);
        done(1);
        w_dir('0);
        wait_grant();
        check(send_idx == 9, "R3 direction change", send_idx, 9);
        done(1);
        w_ackclr('1);

        // R6 grant latency, R7 no pre-emption
        w_req(N'(1) << 3);
        check(send_valid == 0, "R6 not yet", send_valid, 0);
        step();
        check(send_valid == 1 && send_idx == 3, "R6 one clock later", {send_valid, send_idx}, {1'b1, 5'd3});
        w_ctl(20, 50, 1, 7);
        w_req(N'(1) << 20);
        step();
        check(send_valid == 1 && send_idx == 3 && send_prio == 0, "R7 held", {send_idx, send_prio}, {5'd3, 6'd0});
        done(1);
        check(send_valid == 0 && tx_ack[3] == 1, "R8 release", {send_valid, tx_ack[3]}, 2'b01);
        step();
        check(send_idx == 20 && send_prio == 50 && send_rtr == 1 && send_len == 7, "R4 next",
              {send_idx, send_prio}, {5'd20, 6'd50});

        // R9 failed attempt keeps request
        done(0);
        check(send_valid == 0 && tx_req[20] == 1 && tx_ack[20] == 0, "R9 keep",
              {send_valid, tx_req[20], tx_ack[20]}, 3'b010);
        step();
        check(send_valid == 1 && send_idx == 20, "R9 retry", send_idx, 20);
        done(1);

        // R8 done while idle ignored
        send_done = 1; send_ok = 1; step(); send_done = 0; send_ok = 0;
        check(tx_ack == ((N'(1) << 3) | (N'(1) << 20)) && tx_req == 0 && send_valid == 0,
              "R8 idle done ignored", tx_ack, (N'(1) << 3) | (N'(1) << 20));

        // R10 W1C, R11 interrupt mask
        w_ackclr(N'(1) << 3);
        check(tx_ack == (N'(1) << 20), "R10 clear one", tx_ack, N'(1) << 20);
        w_ackclr('0);
        check(tx_ack == (N'(1) << 20), "R10 zero bits", tx_ack, N'(1) << 20);
        check(irq == 0, "R11 masked", irq, 0);
        w_mask(N'(1) << 20);
        check(irq == 1, "R11 enabled", irq, 1);
        w_mask(N'(1) << 3);
        check(irq == 0, "R11 other mask", irq, 0);
        w_ackclr('1);
        w_mask('0);

        // R12 disable cancels pending and in-flight
        w_dir(N'(1) << 7);
        w_req(N'(1) << 7);
        w_en(~(N'(1) << 7));
        check(tx_req == 0 && tx_ack == 0, "R12 pending cancel", {tx_req, tx_ack}, 0);
        w_en('1); w_dir('0);
        w_req(N'(1) << 11);
        wait_grant();
        w_en(~(N'(1) << 11));
        check(tx_req == 0 && send_valid == 1 && send_idx == 11, "R12 in-flight continues",
              {tx_req, send_valid}, {N'(0), 1'b1});
        done(1);
        check(tx_ack == 0 && send_valid == 0, "R12 no ack", tx_ack, 0);
        w_en('1);

        // R13 abort pending and in-flight
        w_dir(N'(1) << 6);
        w_req(N'(1) << 6);
        w_abort(N'(1) << 6);
        check(tx_req == 0, "R13 pending abort", tx_req, 0);
        w_dir('0);
        w_req(N'(1) << 12);
        wait_grant();
        w_abort(N'(1) << 12);
        check(send_valid == 1 && tx_req == 0, "R13 in-flight continues", {send_valid, tx_req}, {1'b1, N'(0)});
        done(1);
        check(tx_ack == 0, "R13 no ack", tx_ack, 0);

        // R1 reset during activity
        w_req(N'(1) << 4);
        wait_grant();
        rst_n = 1'b0;
        #1;
        check(send_valid == 0 && tx_req == 0 && tx_ack == 0 && irq == 0, "R1 mid reset",
              {send_valid, tx_req}, 0);
        step();
        rst_n = 1'b1;
        w_req(N'(1) << 4);
        step(); step();
        check(tx_req == 0 && send_valid == 0, "R1 enables cleared", {tx_req, send_valid}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule